// File: doc/BRIEF.md
# Resolution-Scaled Wake Sleep Timer

This block keeps time while the rest of a chip is idle. A 31-bit counter moves forward once for each pulse of a slow reference tick, and a 2-bit resolution setting picks which 16-bit slice of that counter software sees. Each step of the setting moves the slice up by five bits. Software reads the slice one byte at a time. Reading the low byte freezes the high byte, so the two bytes read one after the other always come from the same sample of the counter.

The same resolution setting scales a programmable 16-bit wake timeout. After that many scaled units of reference ticks, the block raises a one-cycle event pulse and a matching DMA request pulse. It then starts the next period at once, so wake-ups repeat. A port-interrupt vector passes through the block and is forced to zero whenever the sleep-mode input is non-zero. The reference clock source, oscillator trimming and power sequencing live outside this block.

Top module: `wake_sleep_timer`

## Requirements
- R1: The internal 31-bit counter resets to zero. It adds one on each clock edge where `ref_tick` is high and holds its value on every other edge.
- R2: The 16-bit time value is counter bits [15:0], [20:5], [25:10] or [30:15] when `res_sel` is 0, 1, 2 or 3. The selection follows `res_sel` directly.
- R3: Register reads present `reg_rdata` on the cycle after the read strobe, and `reg_rdata` holds when no read is made. A read of address 0 returns time bits [7:0] and latches time bits [15:8] into a shadow byte. A read of address 1 returns that shadow byte. Both bytes read 0x00 after reset, and writes to addresses 0 and 1 change nothing.
- R4: The 16-bit timeout is written and read as its low byte at address 2 and its high byte at address 3. It resets to 0x876B.
- R5: While the timeout E and the active resolution r stay unchanged, `evt_pulse` goes high for one cycle after every E·2^(5·r) ticks.
- R6: A timeout value of zero counts as 65536 units.
- R7: A write to address 2 or 3 restarts the period count. The first event after the write comes a full period after the last such write, and no event pulse appears on the cycle just after the write.
- R8: A change of `res_sel` changes the event period only from the next event onward. The active resolution is 0 after reset.
- R9: `dma_trig` pulses on exactly the cycles where `evt_pulse` is high.
- R10: `port_irq_out` equals `port_irq_in` when `sleep_mode` is 00. It is all zeros for any other `sleep_mode` value.
- R11: No ticks means no progress: with `ref_tick` low, neither the counter nor the period count advances, so no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per slow reference period |
| res_sel | input | 2 | Resolution setting for window and timeout scale |
| sleep_mode | input | 2 | Current sleep mode, 00 means awake |
| port_irq_in | input | 8 | Port interrupt requests |
| port_irq_out | output | 8 | Port interrupt requests after sleep gating |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Byte register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| evt_pulse | output | 1 | Wake event pulse |
| dma_trig | output | 1 | DMA request pulse on each event |

## Verification
The bench builds the block with its default parameters: a 31-bit counter, a 16-bit window, a five-bit step per resolution level and an 8-bit interrupt vector. It drives `ref_tick` high on every cycle, so one unit of the coarsest scale costs 32768 cycles. That makes periods at all four resolutions measurable, along with the 65536-unit zero-timeout case at the finest scale. After about 100k ticks the top window [30:15] holds a non-zero value, so the coarsest slice is checked against real data and not just against zero.

// File: rtl/wst_pkg.sv
package wst_pkg;

    localparam int unsigned WST_CNT_W    = 31;
    localparam int unsigned WST_WIN_W    = 16;
    localparam int unsigned WST_RES_W    = 2;
    localparam int unsigned WST_RES_STEP = 5;
    localparam int unsigned WST_EVT_W    = 16;
    localparam int unsigned WST_BYTE_W   = 8;
    localparam int unsigned WST_ADDR_W   = 2;
    localparam int unsigned WST_MODE_W   = 2;
    localparam int unsigned WST_IRQ_W    = 8;
    localparam logic [WST_EVT_W-1:0] WST_EVT_RST = 16'h876B;

    // Byte register addresses
    typedef enum logic [WST_ADDR_W-1:0] {
        SEL_TIME_LO = 2'd0,
        SEL_TIME_HI = 2'd1,
        SEL_EVT_LO  = 2'd2,
        SEL_EVT_HI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        reg_sel_e              sel;
        logic [WST_BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_evt_sel(input reg_sel_e sel);
        return (sel == SEL_EVT_LO) || (sel == SEL_EVT_HI);
    endfunction

endpackage

// File: rtl/wst_tick_counter.sv
module wst_tick_counter #(
    parameter int unsigned CNT_W = 31,
    parameter int unsigned WIN_W = 16,
    parameter int unsigned RES_W = 2,
    parameter int unsigned STEP  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    output logic [CNT_W-1:0] cnt,
    output logic [WIN_W-1:0] window
);
    localparam int unsigned NRES = 1 << RES_W;

    logic [WIN_W-1:0] slices [NRES];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // One slice per resolution level, each STEP bits above the last
    for (genvar r = 0; r < NRES; r++) begin : g_win
        localparam int unsigned LO = r * STEP;
        if (LO + WIN_W <= CNT_W) begin : g_full
            assign slices[r] = cnt[LO +: WIN_W];
        end else if (LO < CNT_W) begin : g_part
            assign slices[r] = WIN_W'(cnt >> LO);
        end else begin : g_none
            assign slices[r] = '0;
        end
    end

    assign window = slices[res];

endmodule

// File: rtl/wst_event_timer.sv
module wst_event_timer #(
    parameter int unsigned EVT_W = 16,
    parameter int unsigned RES_W = 2,
    parameter int unsigned STEP  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    input  logic [EVT_W-1:0] evt_val,
    input  logic             restart,
    output logic             fire_now,
    output logic             evt_pulse
);
    localparam int unsigned MAX_SH = STEP * ((1 << RES_W) - 1);
    localparam int unsigned TGT_W  = EVT_W + 1 + MAX_SH;

    logic [RES_W-1:0] res_act;
    logic [EVT_W:0]   units;
    logic [TGT_W-1:0] target;
    logic [TGT_W-1:0] last_tick;
    logic [TGT_W-1:0] elapsed;

    always_comb begin
        units     = (evt_val == '0) ? {1'b1, {EVT_W{1'b0}}} : {1'b0, evt_val};
        target    = TGT_W'(units) << (STEP * res_act);
        last_tick = target - 1'b1;
        fire_now  = tick && !restart && (elapsed == last_tick);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed   <= '0;
            res_act   <= '0;
            evt_pulse <= 1'b0;
        end else begin
            evt_pulse <= fire_now;
            if (restart) begin
                elapsed <= '0;
            end else if (fire_now) begin
                elapsed <= '0;
                res_act <= res;
            end else if (tick) begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wst_regs.sv
module wst_regs
    import wst_pkg::*;
#(
    parameter int unsigned    BYTE_W  = WST_BYTE_W,
    parameter int unsigned    EVT_W   = WST_EVT_W,
    parameter int unsigned    WIN_W   = WST_WIN_W,
    parameter logic [EVT_W-1:0] EVT_RST = WST_EVT_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [WIN_W-1:0]  window,
    output logic [BYTE_W-1:0] rdata,
    output logic [EVT_W-1:0]  evt_val,
    output logic              restart
);
    logic [BYTE_W-1:0] hi_shadow;
    logic [EVT_W-1:0]  evt_q;

    assign evt_val = evt_q;
    assign restart = req.wr && is_evt_sel(req.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q     <= EVT_RST;
            hi_shadow <= '0;
            rdata     <= '0;
        end else begin
            if (req.wr) begin
                case (req.sel)
                    SEL_EVT_LO: evt_q[BYTE_W-1:0]     <= req.wdata;
                    SEL_EVT_HI: evt_q[EVT_W-1:BYTE_W] <= req.wdata;
                    default: ;
                endcase
            end
            if (req.rd) begin
                case (req.sel)
                    SEL_TIME_LO: begin
                        rdata     <= window[BYTE_W-1:0];
                        hi_shadow <= window[WIN_W-1:BYTE_W];
                    end
                    SEL_TIME_HI: rdata <= hi_shadow;
                    SEL_EVT_LO:  rdata <= evt_q[BYTE_W-1:0];
                    SEL_EVT_HI:  rdata <= evt_q[EVT_W-1:BYTE_W];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/wake_sleep_timer.sv
module wake_sleep_timer
    import wst_pkg::*;
#(
    parameter int unsigned      CNT_W    = WST_CNT_W,
    parameter int unsigned      WIN_W    = WST_WIN_W,
    parameter int unsigned      RES_W    = WST_RES_W,
    parameter int unsigned      RES_STEP = WST_RES_STEP,
    parameter int unsigned      EVT_W    = WST_EVT_W,
    parameter int unsigned      BYTE_W   = WST_BYTE_W,
    parameter int unsigned      ADDR_W   = WST_ADDR_W,
    parameter int unsigned      MODE_W   = WST_MODE_W,
    parameter int unsigned      IRQ_W    = WST_IRQ_W,
    parameter logic [EVT_W-1:0] EVT_RST  = WST_EVT_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [RES_W-1:0]  res_sel,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic [IRQ_W-1:0]  port_irq_in,
    output logic [IRQ_W-1:0]  port_irq_out,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              evt_pulse,
    output logic              dma_trig
);
    bus_req_t         req;
    logic [CNT_W-1:0] cnt_q;
    logic [WIN_W-1:0] window;
    logic [EVT_W-1:0] evt_val;
    logic             restart;
    logic             fire_now;
    logic             dma_q;

    always_comb begin
        req.rd    = reg_rd;
        req.wr    = reg_wr;
        req.sel   = reg_sel_e'(reg_addr);
        req.wdata = reg_wdata;
    end

    wst_tick_counter #(
        .CNT_W(CNT_W), .WIN_W(WIN_W), .RES_W(RES_W), .STEP(RES_STEP)
    ) u_cnt (
        .clk(clk), .rst(rst), .tick(ref_tick), .res(res_sel),
        .cnt(cnt_q), .window(window)
    );

    wst_regs #(
        .BYTE_W(BYTE_W), .EVT_W(EVT_W), .WIN_W(WIN_W), .EVT_RST(EVT_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .req(req), .window(window),
        .rdata(reg_rdata), .evt_val(evt_val), .restart(restart)
    );

    wst_event_timer #(
        .EVT_W(EVT_W), .RES_W(RES_W), .STEP(RES_STEP)
    ) u_evt (
        .clk(clk), .rst(rst), .tick(ref_tick), .res(res_sel),
        .evt_val(evt_val), .restart(restart),
        .fire_now(fire_now), .evt_pulse(evt_pulse)
    );

    // DMA request registered alongside the event pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            dma_q <= 1'b0;
        end else begin
            dma_q <= fire_now;
        end
    end
    assign dma_trig = dma_q;

    assign port_irq_out = (sleep_mode == '0) ? port_irq_in : '0;

endmodule

// File: rtl/wst_checker.sv
module wst_checker
    import wst_pkg::*;
#(
    parameter int unsigned CNT_W  = WST_CNT_W,
    parameter int unsigned BYTE_W = WST_BYTE_W,
    parameter int unsigned ADDR_W = WST_ADDR_W,
    parameter int unsigned MODE_W = WST_MODE_W,
    parameter int unsigned IRQ_W  = WST_IRQ_W
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic [MODE_W-1:0] sleep_mode,
    input logic [IRQ_W-1:0]  port_irq_out,
    input logic              evt_pulse,
    input logic              dma_trig
);
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> (cnt == $past(cnt) + 1'b1));

    assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(cnt));

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    assert_evt_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> $past(ref_tick));

    assert_no_evt_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == SEL_EVT_LO || reg_addr == SEL_EVT_HI)) |=> !evt_pulse);

    assert_dma_with_event_R9: assert property (@(posedge clk) disable iff (rst)
        dma_trig |-> evt_pulse);

    assert_irq_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode != '0) |-> (port_irq_out == '0));

endmodule

bind wake_sleep_timer wst_checker #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .IRQ_W(IRQ_W)
) u_chk (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cnt(cnt_q),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .sleep_mode(sleep_mode), .port_irq_out(port_irq_out),
    .evt_pulse(evt_pulse), .dma_trig(dma_trig)
);

// File: tb/sim_wake_sleep_timer.sv
module sim_wake_sleep_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic [1:0]  sleep_mode = 2'd0;
    logic [7:0]  port_irq_in = 8'h00;
    logic [7:0]  port_irq_out;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        evt_pulse;
    logic        dma_trig;

    int n_chk = 0;
    int n_fail = 0;
    int dma_mis = 0;
    int dma_seen = 0;
    logic [30:0] model_cnt = '0;
    logic [30:0] snap = '0;
    logic [30:0] lo_snap = '0;
    logic [31:0] exp_win;
    logic [7:0]  rd_val;
    logic [7:0]  rd_hi;
    int cyc;
    int pulses;

    // Expected-period table: res, timeout, first wait after write, steady period
    typedef struct packed {
        logic [1:0]  res;
        logic [15:0] ev;
        logic [31:0] first;
        logic [31:0] period;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 16'd5, 32'd5,    32'd5},
        '{2'd1, 16'd3, 32'd3,    32'd96},
        '{2'd0, 16'd7, 32'd224,  32'd7},
        '{2'd2, 16'd2, 32'd2,    32'd2048},
        '{2'd3, 16'd1, 32'd1024, 32'd32768}
    };

    always #4 clk = ~clk;

    wake_sleep_timer u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .res_sel(res_sel),
        .sleep_mode(sleep_mode), .port_irq_in(port_irq_in), .port_irq_out(port_irq_out),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .dma_trig(dma_trig)
    );

    // Independent tick model
    always @(posedge clk) begin
        if (rst) model_cnt <= '0;
        else if (ref_tick) model_cnt <= model_cnt + 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (dma_trig !== evt_pulse) dma_mis++;
            if (dma_trig) dma_seen++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        snap = model_cnt;
        reg_rd = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic write_evt(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 2'd2;
        reg_wdata = v[7:0];
        @(negedge clk);
        reg_addr = 2'd3;
        reg_wdata = v[15:8];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_event(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!evt_pulse && c < 70000);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        // Reset state (R1, R3, R4, R9)
        repeat (5) @(negedge clk);
        check("R5 evt_pulse in reset", {31'd0, evt_pulse}, 32'd0);
        check("R9 dma_trig in reset", {31'd0, dma_trig}, 32'd0);
        rst = 1'b0;
        bus_read(2'd0, rd_val);
        check("R1/R3 time low after reset", {24'd0, rd_val}, 32'd0);
        bus_read(2'd1, rd_val);
        check("R3 time high after reset", {24'd0, rd_val}, 32'd0);
        bus_read(2'd2, rd_val);
        check("R4 timeout low reset", {24'd0, rd_val}, 32'h6B);
        bus_read(2'd3, rd_val);
        check("R4 timeout high reset", {24'd0, rd_val}, 32'h87);

        // Zero timeout means 65536 units (R6)
        ref_tick = 1'b1;
        res_sel = 2'd0;
        write_evt(16'd0);
        wait_event(cyc);
        check("R6 zero timeout period", cyc, 32'd65536);

        // No ticks, no progress (R11)
        @(negedge clk);
        ref_tick = 1'b0;
        write_evt(16'd2);
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (evt_pulse) pulses++;
        end
        check("R11 no event without ticks", pulses, 32'd0);
        ref_tick = 1'b1;
        wait_event(cyc);
        check("R11 event after ticks resume", cyc, 32'd2);

        // Table of periods (R5, R7, R8)
        for (int i = 0; i < 5; i++) begin
            res_sel = VECS[i].res;
            write_evt(VECS[i].ev);
            wait_event(cyc);
            check("R7/R8 first wait after write", cyc, VECS[i].first);
            wait_event(cyc);
            check("R5 steady period", cyc, VECS[i].period);
        end

        // Window selection and coherent high byte (R2, R3)
        for (int r = 0; r < 4; r++) begin
            res_sel = 2'(r);
            bus_read(2'd0, rd_val);
            lo_snap = snap;
            bus_read(2'd1, rd_hi);
            exp_win = {1'b0, lo_snap} >> (5 * r);
            check("R2 window low byte", {24'd0, rd_val}, {24'd0, exp_win[7:0]});
            check("R3 window high byte", {24'd0, rd_hi}, {24'd0, exp_win[15:8]});
        end
        check("R2 top window nonzero", {31'd0, (exp_win[15:0] != 16'd0)}, 32'd1);

        res_sel = 2'd0;
        bus_read(2'd0, rd_val);
        lo_snap = snap;
        repeat (300) @(negedge clk);
        bus_read(2'd1, rd_hi);
        check("R3 high byte held from low read", {24'd0, rd_hi}, {24'd0, lo_snap[15:8]});
        bus_write(2'd1, 8'hFF);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd1, rd_hi);
        check("R3 writes to time bytes ignored", {24'd0, rd_hi}, {24'd0, lo_snap[15:8]});

        // Timeout readback (R4)
        write_evt(16'hA55A);
        bus_read(2'd2, rd_val);
        check("R4 timeout low readback", {24'd0, rd_val}, 32'h5A);
        bus_read(2'd3, rd_val);
        check("R4 timeout high readback", {24'd0, rd_val}, 32'hA5);

        // Interrupt gating (R10)
        port_irq_in = 8'hA5;
        for (int m = 0; m < 4; m++) begin
            sleep_mode = 2'(m);
            #1;
            check("R10 port irq gating", {24'd0, port_irq_out}, (m == 0) ? 32'hA5 : 32'h0);
        end

        // DMA request tracks every event (R9)
        check("R9 dma mismatches", dma_mis, 32'd0);
        check("R9 dma pulses seen", {31'd0, (dma_seen > 0)}, 32'd1);

        summary();
        $finish;
    end

endmodule